// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a small byte-addressed serial EEPROM. The storage is an internal array of `MEM_BYTES` bytes that resets to zero. The block samples `scl` and `sda_in`, which arrive already synchronized to `clk`. It detects START, repeated START and STOP, and drives the data line only by pulling it low through `sda_oe`.

A transfer begins with a control byte. Its upper seven bits must equal `DEV_ADDR`, and bit 0 selects the direction.

- A write command carries a word address and one data byte. The STOP that ends it launches a programming cycle of `WCYC` clock cycles. The array is updated when that cycle completes.
- During the cycle the block refuses every control byte. A master can therefore poll for completion.
- The `wp` input blocks programming.
- Reads share a single address pointer with writes. Three read forms are supported:
  - current-address reads;
  - random reads, built from a dummy write followed by a repeated START;
  - sequential reads, which continue while the master acknowledges.

The controller is a state machine with nine states:

- `S_IDLE` waits for START.
- `S_CTRL` shifts in the control byte.
- `S_CACK` drives its acknowledge.
- `S_WADDR` and `S_AACK` take and acknowledge the word address.
- `S_WDATA` and `S_DACK` take and acknowledge a data byte.
- `S_RDATA` shifts a byte out.
- `S_RACK` samples the master's acknowledge.

Transitions:

- START from any state goes to `S_CTRL`, and STOP from any state goes to `S_IDLE`.
- After the ninth SCL fall of a byte, the machine moves as follows:
  - `S_CTRL` goes to `S_CACK` when the address matches and no cycle is busy; otherwise it goes to `S_IDLE`.
  - `S_CACK` goes to `S_RDATA` when reading and to `S_WADDR` when writing.
  - `S_WADDR` goes to `S_AACK`, and `S_AACK` goes to `S_WDATA`.
  - `S_WDATA` goes to `S_DACK` for the first data byte and to `S_IDLE` for any later one.
  - `S_DACK` goes back to `S_WDATA`.
  - `S_RDATA` goes to `S_RACK`.
  - `S_RACK` goes back to `S_RDATA` on a master ACK and to `S_IDLE` on a NACK.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, `sda_oe` is low, no programming cycle is pending, the address pointer is 0 and every array byte reads as 0x00.
- R2: The block acknowledges a control byte only when its bits 7:1 equal `DEV_ADDR`. Bit 0 is the direction: 1 means read and 0 means write. On a mismatch the block leaves the acknowledge slot high and ignores the bus until the next START.
- R3: A write command (control byte, word address, data byte, then STOP) is acknowledged on every byte. The array location given by the low log2(`MEM_BYTES`) bits of the word address holds the data once the programming cycle has finished.
- R4: A programming cycle starts only on the STOP of a write command that carried a data byte, and lasts `WCYC` clock cycles. Any control byte received while the cycle runs is not acknowledged. Control bytes are acknowledged again once the cycle has finished.
- R5: A repeated START that follows a data byte ends the write without programming. No busy period follows, and the location keeps its old value.
- R6: In a random read (write command carrying only the word address, then a repeated START, then a read control byte), the first byte returned is the one at that address. Bytes are sent MSB first.
- R7: A current-address read returns the byte at n+1 when the previous completed byte access, read or write, was at n.
- R8: When the master acknowledges a read byte, the next byte follows at the next address. The pointer wraps from `MEM_BYTES`-1 to 0. When the master sends NACK and then STOP, the transfer ends.
- R9: While `wp` is high at STOP, every byte of a write command is still acknowledged, but no programming cycle starts. The next control byte is acknowledged at once and the array is unchanged.
- R10: Only one data byte is taken per write command. A second data byte is not acknowledged and is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Synchronized serial clock |
| sda_in | input | 1 | Synchronized serial data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |
| wp | input | 1 | Write protect, blocks programming when 1 |

## Verification
The bench builds the block with `MEM_BYTES` = 16 and `WCYC` = 200.

The small array brings the pointer wrap from address 15 to 0 into a single short sequential read. A 200-cycle programming time outlasts the roughly 90 cycles that one polling control byte takes. The first poll after a write therefore lands inside the busy window, and a few later polls see it end.

`DEV_ADDR` stays at 0x50, so both a matching control byte and a neighbouring mismatching one are exercised.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CACK,
        S_WADDR,
        S_AACK,
        S_WDATA,
        S_DACK,
        S_RDATA,
        S_RACK
    } eep_state_e;
endpackage

// File: rtl/eep_busmon.sv
module eep_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic cond_start,
    output logic cond_stop,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Data edges while the clock stays high are bus conditions.
    assign cond_start = scl && scl_q && sda_q && !sda;
    assign cond_stop  = scl && scl_q && !sda_q && sda;
    assign scl_rise   = scl && !scl_q;
    assign scl_fall   = !scl && scl_q;
endmodule

// File: rtl/eep_wcycle.sv
module eep_wcycle #(
    parameter int WCYC = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WCYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (launch) begin
            cnt <= CW'(WCYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    p_launch_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);
    p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(WCYC));
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
    parameter logic [6:0] DEV_ADDR  = 7'h50,
    parameter int         MEM_BYTES = 256,
    parameter int         WCYC      = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda_in,
    output logic sda_oe,
    input  logic wp
);
    import eep_pkg::*;

    localparam int AW = $clog2(MEM_BYTES);

    eep_state_e    state, nxt;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [AW-1:0] ptr;
    logic [AW-1:0] paddr;
    logic [7:0]    pdata;
    logic          rw;
    logic          mack;
    logic          pend_wr;
    logic          cond_start, cond_stop, scl_rise, scl_fall;
    logic          busy, done, launch;
    logic [7:0]    rd_data;
    logic          byte_end;

    eep_busmon i_busmon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (scl),
        .sda        (sda_in),
        .cond_start (cond_start),
        .cond_stop  (cond_stop),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall)
    );

    eep_wcycle #(.WCYC(WCYC)) i_wcycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .busy   (busy),
        .done   (done)
    );

    eep_array #(.DEPTH(MEM_BYTES), .AW(AW)) i_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (done),
        .waddr (paddr),
        .wdata (pdata),
        .raddr (ptr),
        .rdata (rd_data)
    );

    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign launch   = cond_stop && pend_wr && !wp;

    // Next-state logic.
    always_comb begin
        nxt = state;
        if (cond_start) begin
            nxt = S_CTRL;
        end else if (cond_stop) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_CTRL:  if (byte_end)
                             nxt = (shreg[7:1] == DEV_ADDR && !busy) ? S_CACK : S_IDLE;
                S_CACK:  if (scl_fall) nxt = rw ? S_RDATA : S_WADDR;
                S_WADDR: if (byte_end) nxt = S_AACK;
                S_AACK:  if (scl_fall) nxt = S_WDATA;
                S_WDATA: if (byte_end) nxt = pend_wr ? S_IDLE : S_DACK;
                S_DACK:  if (scl_fall) nxt = S_WDATA;
                S_RDATA: if (byte_end) nxt = S_RACK;
                S_RACK:  if (scl_fall) nxt = mack ? S_RDATA : S_IDLE;
                default: nxt = S_IDLE;
            endcase
        end
    end

    // State register and datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            ptr     <= '0;
            paddr   <= '0;
            pdata   <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            pend_wr <= 1'b0;
        end else begin
            state <= nxt;
            if (cond_start || cond_stop) begin
                bitcnt  <= '0;
                pend_wr <= 1'b0;
            end else begin
                unique case (state)
                    S_CTRL, S_WADDR, S_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_in};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                            if (state == S_CTRL) rw <= shreg[0];
                            if (state == S_WADDR) ptr <= shreg[AW-1:0];
                            if (state == S_WDATA && !pend_wr) begin
                                pdata   <= shreg;
                                paddr   <= ptr;
                                ptr     <= ptr + AW'(1);
                                pend_wr <= 1'b1;
                            end
                        end
                    end
                    S_CACK: begin
                        if (scl_fall && rw) begin
                            shreg  <= rd_data;
                            ptr    <= ptr + AW'(1);
                            bitcnt <= '0;
                        end
                    end
                    S_RDATA: begin
                        if (scl_rise && bitcnt != 4'd8) bitcnt <= bitcnt + 4'd1;
                        else if (scl_fall && bitcnt != 4'd8) shreg <= {shreg[6:0], 1'b0};
                    end
                    S_RACK: begin
                        if (scl_rise) mack <= !sda_in;
                        else if (scl_fall && mack) begin
                            shreg  <= rd_data;
                            ptr    <= ptr + AW'(1);
                            bitcnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output logic.
    always_comb begin
        unique case (state)
            S_CACK, S_AACK, S_DACK: sda_oe = 1'b1;
            S_RDATA:                sda_oe = !shreg[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    p_ack_not_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_CACK) |-> !busy);
    p_prog_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cond_stop));
    p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(wp));
    p_restart_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cond_start |=> !pend_wr);
    p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_oe);
endmodule

// File: tb/test_i2c_eeprom_target.sv
module test_i2c_eeprom_target;
    localparam int CLK_P = 10;
    localparam int HALF  = 4;
    localparam int MEMB  = 16;
    localparam int WCY   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_in;

    assign sda_in = m_sda & ~sda_oe;

    always #(CLK_P/2) clk = ~clk;

    i2c_eeprom_target #(.DEV_ADDR(7'h50), .MEM_BYTES(MEMB), .WCYC(WCY)) i_i2c_eeprom_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl    (scl),
        .sda_in (sda_in),
        .sda_oe (sda_oe),
        .wp     (wp)
    );

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] v;
        string      req;
    } exp_t;
    exp_t exp_q[$];
    logic [7:0] got_byte;
    event got_ev;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected read bytes and compares them with what came off the bus.
    initial begin
        forever begin
            @(got_ev);
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", got_byte, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(got_byte == e.v, e.req, got_byte, e.v);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; tick(HALF);
        scl = 1'b1;   tick(HALF);
        m_sda = 1'b0; tick(HALF);
        scl = 1'b0;   tick(HALF);
    endtask

    task automatic i2c_stop;
        m_sda = 1'b0; tick(HALF);
        scl = 1'b1;   tick(HALF);
        m_sda = 1'b1; tick(HALF);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        m_sda = b; tick(HALF);
        scl = 1'b1; tick(HALF);
        s = sda_in;
        scl = 1'b0; tick(2);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        ack = !s;
    endtask

    // Driver side of the scoreboard: push the expected byte, then read it.
    task automatic rbyte(input bit send_ack, input logic [7:0] expv, input string req);
        logic s;
        logic [7:0] v;
        exp_q.push_back('{v: expv, req: req});
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        bit_xfer(!send_ack, s);
        got_byte = v;
        -> got_ev;
        tick(1);
    endtask

    task automatic write_byte(input logic [7:0] a, input logic [7:0] d, input string req);
        bit ack;
        i2c_start;
        wbyte(8'hA0, ack); check(ack, req, ack, 1);
        wbyte(a, ack);     check(ack, req, ack, 1);
        wbyte(d, ack);     check(ack, req, ack, 1);
        i2c_stop;
    endtask

    task automatic set_addr_read(input logic [7:0] a, input string req);
        bit ack;
        i2c_start;
        wbyte(8'hA0, ack); check(ack, req, ack, 1);
        wbyte(a, ack);     check(ack, req, ack, 1);
        i2c_start;
        wbyte(8'hA1, ack); check(ack, req, ack, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit ack;
        bit first;
        int polls;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        i2c_start;
        wbyte(8'hA1, ack); check(ack, "R2 read control acked", ack, 1);
        rbyte(1'b0, 8'h00, "R1 byte at pointer 0 after reset");
        i2c_stop;

        // R2: mismatching device address
        i2c_start;
        wbyte(8'hA2, ack); check(!ack, "R2 wrong address NACK", ack, 0);
        i2c_stop;
        check(sda_oe == 1'b0, "R2 released after mismatch", sda_oe, 0);

        // R3, R4: byte write and busy polling
        write_byte(8'h05, 8'h3C, "R3 write acked");
        polls = 0;
        first = 1'b1;
        do begin
            i2c_start;
            wbyte(8'hA0, ack);
            if (polls == 0) first = ack;
            if (!ack) i2c_stop;
            polls++;
        end while (!ack && polls < 20);
        check(first == 1'b0, "R4 NACK while programming", first, 0);
        check(ack == 1'b1, "R4 ACK after cycle ends", ack, 1);
        i2c_stop;

        // R7: current address after write at 5
        i2c_start;
        wbyte(8'hA1, ack); check(ack, "R7 control", ack, 1);
        rbyte(1'b0, 8'h00, "R7 current read at n+1");
        i2c_stop;

        // R6: random read
        set_addr_read(8'h05, "R6 random read setup");
        rbyte(1'b0, 8'h3C, "R6 random read data MSB first");
        i2c_stop;

        // R5: repeated START after data discards the write
        i2c_start;
        wbyte(8'hA0, ack); check(ack, "R5 control", ack, 1);
        wbyte(8'h09, ack); check(ack, "R5 address", ack, 1);
        wbyte(8'h77, ack); check(ack, "R5 data", ack, 1);
        i2c_start;
        wbyte(8'hA1, ack); check(ack, "R5 no busy after restart", ack, 1);
        rbyte(1'b0, 8'h00, "R5 pointer after discarded data");
        i2c_stop;
        set_addr_read(8'h09, "R5 readback setup");
        rbyte(1'b0, 8'h00, "R5 location unchanged");
        i2c_stop;

        // R8: sequential read with wrap
        write_byte(8'h0F, 8'hA5, "R8 write 15");
        tick(WCY + 20);
        write_byte(8'h00, 8'h11, "R8 write 0");
        tick(WCY + 20);
        set_addr_read(8'h0E, "R8 setup");
        rbyte(1'b1, 8'h00, "R8 seq byte 14");
        rbyte(1'b1, 8'hA5, "R8 seq byte 15");
        rbyte(1'b1, 8'h11, "R8 seq wrap to 0");
        rbyte(1'b0, 8'h00, "R8 seq byte 1");
        i2c_stop;
        check(sda_oe == 1'b0, "R8 transfer ended", sda_oe, 0);

        // R9: write protect
        wp = 1'b1;
        write_byte(8'h03, 8'hEE, "R9 write acked under wp");
        i2c_start;
        wbyte(8'hA0, ack); check(ack, "R9 no busy under wp", ack, 1);
        i2c_stop;
        wp = 1'b0;
        tick(WCY + 20);
        set_addr_read(8'h03, "R9 readback setup");
        rbyte(1'b0, 8'h00, "R9 array unchanged");
        i2c_stop;

        // R10: second data byte refused
        i2c_start;
        wbyte(8'hA0, ack); check(ack, "R10 control", ack, 1);
        wbyte(8'h07, ack); check(ack, "R10 address", ack, 1);
        wbyte(8'h42, ack); check(ack, "R10 first data", ack, 1);
        wbyte(8'h43, ack); check(!ack, "R10 second data NACK", ack, 0);
        i2c_stop;
        tick(WCY + 20);
        set_addr_read(8'h07, "R10 readback setup");
        rbyte(1'b1, 8'h42, "R10 first byte stored");
        rbyte(1'b0, 8'h00, "R10 second byte discarded");
        i2c_stop;

        tick(10);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule